// File: doc/BRIEF.md
# SPI flash command engine

A memory-mapped SPI host that runs one flash command at a time. Software loads an opcode register, an outgoing byte count, an incoming byte count and the outgoing payload. The payload goes into a byte buffer that software addresses directly. A write of the start code to the trigger register then launches the command.

The engine drops chip select and sends the opcode. It then shifts out the payload bytes and clocks in the requested number of reply bytes. Each reply byte lands in the same buffer, right after the payload. A busy flag in the status word stays high for the whole command. Software polls the flag, then reads the reply from buffer offset `txn` onward.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset `busy` is 0, `cs_n` is 1, `sclk` is 0, and the status word at address 0x04 reads 0.
- R2: When idle, byte writes take effect at these addresses, and each one reads back zero-extended on `rdata`:
  - opcode at 0x00, outgoing count at 0x01, incoming count at 0x02;
  - buffer byte k at 0x40+k, for k from 0 to 70.
  - The status word at 0x04 carries busy in bit 0.
- R3: On `mosi` the opcode goes out first and the outgoing bytes follow from buffer offsets 0 to txn-1. Every byte is MSB first. `mosi` is 0 through the whole incoming phase.
- R4: The link runs in mode 0. `sclk` idles low, `mosi` changes only while `sclk` is low, and `miso` is sampled on each rising `sclk`.
- R5: Incoming byte k is stored at buffer offset txn+k. Bits seen on `miso` during the opcode and outgoing phases are not stored.
- R6: Buffer bytes at offsets 0 to txn-1 keep their contents across a command.
- R7: `busy` rises on the clock edge that takes the start write. It stays high for exactly DIV*8*(1+txn+rxn) clock cycles, which gives 8*(1+txn+rxn) `sclk` pulses. `cs_n` is low whenever a pulse occurs.
- R8: A trigger write made while busy is ignored. This includes a write taken in the final cycle of a command.
- R9: Writes to the opcode, count and buffer addresses made while busy are discarded, and they do not change the command in progress.
- R10: With rxn=0 the command ends right after the last outgoing bit. With txn=0 the incoming phase follows the opcode directly.
- R11: Only the value 0x01 written to address 0x03 starts a command. Any other value leaves the engine idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Byte write strobe |
| addr | input | 8 | Register or buffer address |
| wdata | input | 8 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| busy | output | 1 | Command in progress |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
Two events can fall in the same cycle: a host trigger write, and the final falling `sclk` edge that ends a command. The bench counts clock cycles from the accepted start and places a second trigger write on exactly the cycle of that final edge. It then expects `busy` to drop and stay low, with no further `sclk` pulses. Random commands, whose payload, counts and slave reply come from a fixed-seed generator, are compared against expected bit streams and buffer contents built in the bench.

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine #(
  parameter int DEPTH = 71,
  parameter int DIV = 4,
  parameter logic [7:0] FIFO_BASE = 8'h40
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  addr,
  input  logic [7:0]  wdata,
  output logic [31:0] rdata,
  output logic        busy,
  output logic        sclk,
  output logic        cs_n,
  output logic        mosi,
  input  logic        miso
);
  localparam int HALF = DIV / 2;
  localparam int CW = $clog2(HALF) + 1;
  localparam int FW = $clog2(DEPTH);
  localparam logic [7:0] A_OPC = 8'h00, A_TXN = 8'h01, A_RXN = 8'h02,
                         A_TRIG = 8'h03, A_STAT = 8'h04;

  logic [7:0] opcode_q, txn_q, rxn_q, tx_sh, rx_sh;
  logic [7:0] mem [DEPTH];
  logic       busy_q, sclk_q;
  logic [CW-1:0] div_cnt;
  logic [2:0] bit_idx;
  logic [8:0] byte_idx;

  wire [8:0] last_byte = {1'b0, txn_q} + {1'b0, rxn_q};
  wire [8:0] fifo_rel  = {1'b0, addr} - {1'b0, FIFO_BASE};
  wire       fifo_hit  = (addr >= FIFO_BASE) && (fifo_rel < 9'(DEPTH));
  wire       host_wr   = wr_en && !busy_q;
  wire       start     = host_wr && addr == A_TRIG && wdata == 8'h01;
  wire       tick      = busy_q && div_cnt == CW'(HALF - 1);
  wire       rise      = tick && !sclk_q;
  wire       fall      = tick && sclk_q;
  wire       byte_end  = fall && bit_idx == 3'd7;
  wire       done      = byte_end && byte_idx == last_byte;
  wire [8:0] rx_ptr    = byte_idx - 9'd1;
  wire       rx_store  = byte_end && byte_idx > {1'b0, txn_q} && rx_ptr < 9'(DEPTH);
  wire       next_tx   = byte_idx < {1'b0, txn_q} && byte_idx < 9'(DEPTH);

  assign busy = busy_q;
  assign sclk = sclk_q;
  assign cs_n = !busy_q;
  assign mosi = tx_sh[7];

  always_comb begin
    case (addr)
      A_OPC:   rdata = {24'b0, opcode_q};
      A_TXN:   rdata = {24'b0, txn_q};
      A_RXN:   rdata = {24'b0, rxn_q};
      A_STAT:  rdata = {31'b0, busy_q};
      default: rdata = fifo_hit ? {24'b0, mem[fifo_rel[FW-1:0]]} : 32'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (host_wr && fifo_hit) mem[fifo_rel[FW-1:0]] <= wdata;
    else if (rx_store) mem[rx_ptr[FW-1:0]] <= rx_sh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opcode_q <= '0; txn_q <= '0; rxn_q <= '0;
      busy_q <= 1'b0; sclk_q <= 1'b0; div_cnt <= '0;
      bit_idx <= '0; byte_idx <= '0; tx_sh <= '0; rx_sh <= '0;
    end else begin
      if (host_wr) begin
        if (addr == A_OPC) opcode_q <= wdata;
        if (addr == A_TXN) txn_q <= wdata;
        if (addr == A_RXN) rxn_q <= wdata;
      end
      if (start) begin
        busy_q <= 1'b1; sclk_q <= 1'b0; div_cnt <= '0;
        bit_idx <= '0; byte_idx <= '0; tx_sh <= opcode_q;
      end else if (busy_q) begin
        div_cnt <= tick ? '0 : div_cnt + 1'b1;
        if (rise) begin
          sclk_q <= 1'b1;
          rx_sh <= {rx_sh[6:0], miso};
        end
        if (fall) begin
          sclk_q <= 1'b0;
          if (bit_idx == 3'd7) begin
            bit_idx <= '0;
            if (done) busy_q <= 1'b0;
            else begin
              byte_idx <= byte_idx + 9'd1;
              tx_sh <= next_tx ? mem[byte_idx[FW-1:0]] : 8'h00;
            end
          end else begin
            bit_idx <= bit_idx + 3'd1;
            tx_sh <= {tx_sh[6:0], 1'b0};
          end
        end
      end
    end
  end

  a_r7_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy_q && !sclk_q);
  a_r11_start_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(wr_en && addr == A_TRIG && wdata == 8'h01));
  a_r9_opcode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && wr_en && addr == A_OPC |=> $stable(opcode_q));
  a_r4_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && sclk_q |-> $stable(mosi));
  a_r3_rx_mosi_low: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && byte_idx > {1'b0, txn_q} |-> !mosi);
  a_r4_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |=> !sclk_q || busy_q);
endmodule

// File: tb/spi_cmd_engine_tb.sv
module spi_cmd_engine_tb;
  localparam int DIV = 4;
  localparam int DEPTH = 71;
  logic clk = 0, rst_n = 0, wr_en = 0, miso;
  logic [7:0] addr = 0, wdata = 0;
  logic [31:0] rdata;
  logic busy, sclk, cs_n, mosi;
  int n_cmp = 0, n_bad = 0, bcnt = 0, cs_bad = 0, cycles = 0;
  logic [0:575] sbits, mbits;
  logic [7:0] fexp [0:DEPTH-1];

  always #2 clk = ~clk;

  spi_cmd_engine #(.DEPTH(DEPTH), .DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .busy(busy), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso));

  assign miso = (bcnt < 576) ? sbits[bcnt] : 1'b0;

  always @(posedge sclk) begin
    if (bcnt < 576) mbits[bcnt] = mosi;
    if (cs_n) cs_bad++;
    bcnt++;
  end

  always @(posedge clk) cycles++;

  function automatic logic [7:0] sbyte(int j);
    for (int b = 0; b < 8; b++) sbyte[7-b] = sbits[j*8+b];
  endfunction
  function automatic logic [7:0] mbyte(int j);
    for (int b = 0; b < 8; b++) mbyte[7-b] = mbits[j*8+b];
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; #1 v = rdata;
  endtask

  // mode 0: plain, 1: writes while busy, 2: trigger on final cycle
  task automatic run(logic [7:0] op, int tx, int rx, int mode);
    int n, cyc, e0;
    logic [31:0] v;
    n = 1 + tx + rx;
    wr(8'h00, op); wr(8'h01, 8'(tx)); wr(8'h02, 8'(rx));
    for (int k = 0; k < tx; k++) begin
      fexp[k] = 8'($urandom);
      wr(8'h40 + 8'(k), fexp[k]);
    end
    for (int k = 0; k < 72; k++)
      for (int b = 0; b < 8; b++) sbits[k*8+b] = 1'($urandom);
    bcnt = 0; cs_bad = 0; mbits = '0;
    wr(8'h03, 8'h01);
    cyc = 0;
    if (mode == 1) begin
      wr(8'h00, ~op); wr(8'h01, 8'(tx + 1)); wr(8'h40, ~fexp[0]);
      if (tx > 0) fexp[0] = fexp[0];
      wr(8'h03, 8'h01);
      while (busy) @(negedge clk);
      rd(8'h00, v); chk(v == {24'b0, op}, "R9 opcode kept", v, op);
      rd(8'h01, v); chk(v == 32'(tx), "R9 txn kept", v, tx);
      if (tx > 0) begin
        rd(8'h40, v); chk(v[7:0] == fexp[0], "R9 fifo kept", v, fexp[0]);
      end
      chk(bcnt == 8*n, "R8 no retrigger pulses", bcnt, 8*n);
    end else if (mode == 2) begin
      repeat (DIV*8*n - 2) @(negedge clk);
      wr(8'h03, 8'h01);
      chk(busy == 0, "R8 final-cycle trigger busy", busy, 0);
      e0 = bcnt;
      repeat (40) @(negedge clk);
      chk(busy == 0 && bcnt == e0, "R8 final-cycle trigger ignored", bcnt, e0);
    end else begin
      do begin @(negedge clk); cyc++; end while (busy && cyc < 100000);
      chk(cyc == DIV*8*n, (rx == 0 || tx == 0) ? "R10 busy length" : "R7 busy length",
          cyc, DIV*8*n);
    end
    chk(bcnt == 8*n, "R7 pulse count", bcnt, 8*n);
    chk(cs_bad == 0, "R7 cs low at pulses", cs_bad, 0);
    chk(mbyte(0) == op, "R3 opcode first", mbyte(0), op);
    for (int k = 0; k < tx; k++)
      chk(mbyte(1+k) == fexp[k], "R3 tx byte", mbyte(1+k), fexp[k]);
    for (int k = 0; k < rx; k++)
      chk(mbyte(1+tx+k) == 0, "R3 mosi low in rx", mbyte(1+tx+k), 0);
    for (int k = 0; k < tx; k++) begin
      rd(8'h40 + 8'(k), v);
      chk(v[7:0] == fexp[k], "R6 tx kept", v, fexp[k]);
    end
    for (int k = 0; k < rx; k++) begin
      rd(8'h40 + 8'(tx + k), v);
      chk(v[7:0] == sbyte(1+tx+k), "R5 R4 rx stored", v, sbyte(1+tx+k));
    end
  endtask

  initial begin
    logic [31:0] v;
    int t, r, e0;
    void'($urandom(32'd20240611));
    sbits = '0; mbits = '0;
    repeat (3) @(negedge clk);
    chk(busy == 0 && cs_n == 1 && sclk == 0, "R1 reset pins", {busy, cs_n, sclk}, 3'b010);
    rd(8'h04, v); chk(v == 0, "R1 status", v, 0);
    rst_n = 1;
    wr(8'h00, 8'h9F); rd(8'h00, v); chk(v == 32'h9F, "R2 opcode rb", v, 32'h9F);
    wr(8'h02, 8'h11); rd(8'h02, v); chk(v == 32'h11, "R2 rxn rb", v, 32'h11);
    wr(8'h86, 8'h5A); rd(8'h86, v); chk(v == 32'h5A, "R2 last fifo rb", v, 32'h5A);
    e0 = bcnt;
    wr(8'h03, 8'h02); repeat (20) @(negedge clk);
    chk(busy == 0 && bcnt == e0, "R11 wrong code ignored", bcnt, e0);
    run(8'h03, 0, 0, 0);
    run(8'h0B, 0, 6, 0);
    run(8'h02, 5, 0, 0);
    run(8'hAB, 30, 41, 0);
    run(8'h05, 2, 3, 1);
    run(8'h3B, 2, 2, 2);
    for (int i = 0; i < 14; i++) begin
      t = $urandom_range(0, 40);
      r = $urandom_range(0, DEPTH - t);
      run(8'($urandom), t, r, 0);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    wait (cycles > 190000);
    n_bad++; n_cmp++;
    $display("FAIL watchdog actual=%0d expected=0", cycles);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule